// File: doc/BRIEF.md
# Byte-Store Access Engine with Record Burst Loader

This block lets a host perform single-byte reads and writes on an external byte store (typically a serial EEPROM behind a wire-protocol engine). It can also start a burst that walks the store byte by byte, parses fixed-size records and writes one 32-bit word per record into on-chip memory. The host sees five registers, selected by a 3-bit index: control (select 0: bit 1 read request, bit 0 write request), store address (select 1), data byte (select 2), memory base (select 3, 9 bits) and burst start (select 4, bit 0). A register selected at one clock edge appears on `host_rdata` after the next edge.

The store side is a request/acknowledge byte port. The block holds `ee_req` together with its address, write flag and write data steady until the store answers with a one-cycle `ee_ack`, and the store returns `ee_rdata` in that same cycle. The memory side is a registered word write port with a 24-bit address.

A burst record is six bytes long. The first two bytes form a 16-bit address field, low byte first. The next four bytes form a data word, least significant byte first. The memory address is the base register placed over bits [23:15], with bits [14:0] taken from the address field. Bit 15 of the field has no effect.

Top module: `eeb_loader`

## Requirements
- R1: After reset, all five host registers read 0, `ee_req` is low and `mem_we` is low.
- R2: Writing control with bit 0 set (bit 1 clear) stores the data byte at the store address. Control reads 0 again once the store has acknowledged.
- R3: Writing control with bit 1 set loads the byte at the store address into the data register, and control reads 0 again after that. When both bits are set, only the read is performed.
- R4: `ee_req` stays high, with address, write flag and write data unchanged, until the cycle in which `ee_ack` is seen.
- R5: Writing 1 to burst start bit 0 starts a burst. Burst start reads 1 while the burst runs and clears itself when the burst ends.
- R6: A burst started after reset, before any single access, begins at store address 0.
- R7: Any other burst begins at the store address that follows the last byte accessed. After the top address, this next address wraps to 0.
- R8: Each complete record produces one pulse on `mem_we`, with `mem_addr` = {base[8:0], field[14:0]} and `mem_wdata` = the four data bytes in little-endian order.
- R9: A record whose address field is 0xFFFF ends the burst after its second byte, and no memory write is made for it.
- R10: The burst ends right after the byte at the top store address has been read. A word is written only if that byte completed a record.
- R11: A host write to any register while a single access or a burst is in progress has no effect.
- R12: Single reads and writes never cause a memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 3 | Register select (0 control, 1 address, 2 data, 3 base, 4 burst) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read-back of the selected register |
| ee_req | output | 1 | Store access request |
| ee_we | output | 1 | Store access is a write |
| ee_addr | output | EE_AW | Store byte address |
| ee_wdata | output | 8 | Store write byte |
| ee_rdata | input | 8 | Store read byte, valid with ee_ack |
| ee_ack | input | 1 | Store access done (one cycle) |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 32 | Memory word data |

## Verification
The bench targets the start address of each burst. It runs a fresh burst from 0, a burst that resumes after a single read, and a burst that resumes at 0 after a wrap. A design that kept no resume pointer, or that failed to wrap it, would write the wrong records. A record with bit 15 of its field set checks that this bit is dropped, and a terminator record checks that it causes no extra write. A burst that runs into the top address must stop after writing exactly one word. A burst of requests issued during a busy read must leave the address, the data and the store contents untouched. Setting both control bits must read the store and must not overwrite the byte.

// File: rtl/eeb_pkg.sv
package eeb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SINGLE, ST_BURST} eeb_state_e;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_ADDR  = 3'd1;
  localparam logic [2:0] SEL_DATA  = 3'd2;
  localparam logic [2:0] SEL_BASE  = 3'd3;
  localparam logic [2:0] SEL_BURST = 3'd4;

  localparam int REC_BYTES = 6;
  localparam int IDX_W = $clog2(REC_BYTES);
endpackage

// File: rtl/eeb_port.sv
module eeb_port #(
  parameter int EE_AW = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             issue_we,
  input  logic [EE_AW-1:0] issue_addr,
  input  logic [7:0]       issue_wdata,
  input  logic             ee_ack,
  output logic             ee_req,
  output logic             ee_we,
  output logic [EE_AW-1:0] ee_addr,
  output logic [7:0]       ee_wdata,
  output logic             done
);
  assign done = ee_req && ee_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      ee_req   <= 1'b0;
      ee_we    <= 1'b0;
      ee_addr  <= '0;
      ee_wdata <= '0;
    end else if (issue) begin
      ee_req   <= 1'b1;
      ee_we    <= issue_we;
      ee_addr  <= issue_addr;
      ee_wdata <= issue_wdata;
    end else if (done) begin
      ee_req <= 1'b0;
    end
  end
endmodule

// File: rtl/eeb_record.sv
module eeb_record
  import eeb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        take,
  input  logic [7:0]  din,
  output logic        term,
  output logic        rec_done,
  output logic [15:0] field,
  output logic [31:0] word
);
  logic [IDX_W-1:0] idx;
  logic [15:0]      field_q;
  logic [23:0]      word_q;

  assign field    = field_q;
  assign word     = {din, word_q};
  assign term     = take && (idx == IDX_W'(1)) && (din == 8'hFF) && (field_q[7:0] == 8'hFF);
  assign rec_done = take && (idx == IDX_W'(REC_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx     <= '0;
      field_q <= '0;
      word_q  <= '0;
    end else if (take) begin
      case (idx)
        IDX_W'(0): field_q[7:0]   <= din;
        IDX_W'(1): field_q[15:8]  <= din;
        IDX_W'(2): word_q[7:0]    <= din;
        IDX_W'(3): word_q[15:8]   <= din;
        IDX_W'(4): word_q[23:16]  <= din;
        default: ;
      endcase
      idx <= (idx == IDX_W'(REC_BYTES - 1)) ? '0 : idx + 1'b1;
    end
  end
endmodule

// File: rtl/eeb_loader.sv
module eeb_loader
  import eeb_pkg::*;
#(
  parameter int EE_AW  = 10,
  parameter int BASE_W = 9,
  parameter int MEM_AW = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [2:0]        host_sel,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              ee_req,
  output logic              ee_we,
  output logic [EE_AW-1:0]  ee_addr,
  output logic [7:0]        ee_wdata,
  input  logic [7:0]        ee_rdata,
  input  logic              ee_ack,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata
);
  localparam int LOW_W = MEM_AW - BASE_W;
  localparam logic [EE_AW-1:0] EE_TOP = '1;

  eeb_state_e        st;
  logic [EE_AW-1:0]  addr_q, nxt_q;
  logic [7:0]        data_q;
  logic [BASE_W-1:0] base_q;
  logic              fresh_q;

  logic busy, acc, start_single, start_burst, done;
  logic b_take, b_end, b_next, term, rec_done;
  logic issue, issue_we;
  logic [EE_AW-1:0] issue_addr, after_addr;
  logic [15:0] field;
  logic [31:0] word;

  assign busy         = (st != ST_IDLE);
  assign acc          = host_we && !busy;
  assign start_single = acc && (host_sel == SEL_CTRL) && (host_wdata[1] || host_wdata[0]);
  assign start_burst  = acc && (host_sel == SEL_BURST) && host_wdata[0];
  assign after_addr   = ee_addr + 1'b1;
  assign b_take       = done && (st == ST_BURST);
  assign b_end        = b_take && (term || (ee_addr == EE_TOP));
  assign b_next       = b_take && !b_end;
  assign issue        = start_single || start_burst || b_next;
  assign issue_we     = start_single && !host_wdata[1];
  assign issue_addr   = start_single ? addr_q :
                        start_burst  ? (fresh_q ? '0 : nxt_q) : after_addr;

  logic unused_bits;
  assign unused_bits = ^{host_wdata[31:EE_AW], field[15:LOW_W]};

  eeb_port #(.EE_AW(EE_AW)) u_port (
    .clk(clk), .rst(rst), .issue(issue), .issue_we(issue_we),
    .issue_addr(issue_addr), .issue_wdata(data_q), .ee_ack(ee_ack),
    .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
    .done(done)
  );

  eeb_record u_rec (
    .clk(clk), .rst(rst), .clear(start_burst), .take(b_take), .din(ee_rdata),
    .term(term), .rec_done(rec_done), .field(field), .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      addr_q    <= '0;
      nxt_q     <= '0;
      data_q    <= '0;
      base_q    <= '0;
      fresh_q   <= 1'b1;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= rec_done;
      if (rec_done) begin
        mem_addr  <= {base_q, field[LOW_W-1:0]};
        mem_wdata <= word;
      end
      if (acc) begin
        case (host_sel)
          SEL_ADDR: addr_q <= host_wdata[EE_AW-1:0];
          SEL_DATA: data_q <= host_wdata[7:0];
          SEL_BASE: base_q <= host_wdata[BASE_W-1:0];
          default: ;
        endcase
      end
      case (st)
        ST_IDLE: begin
          if (start_single) st <= ST_SINGLE;
          else if (start_burst) st <= ST_BURST;
        end
        ST_SINGLE: begin
          if (done) begin
            st      <= ST_IDLE;
            nxt_q   <= after_addr;
            fresh_q <= 1'b0;
            if (!ee_we) data_q <= ee_rdata;
          end
        end
        default: begin
          if (b_end) begin
            st      <= ST_IDLE;
            nxt_q   <= after_addr;
            fresh_q <= 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else begin
      case (host_sel)
        SEL_CTRL:  host_rdata <= {30'd0, (st == ST_SINGLE) && !ee_we, (st == ST_SINGLE) && ee_we};
        SEL_ADDR:  host_rdata <= 32'(addr_q);
        SEL_DATA:  host_rdata <= 32'(data_q);
        SEL_BASE:  host_rdata <= 32'(base_q);
        SEL_BURST: host_rdata <= {31'd0, st == ST_BURST};
        default:   host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/eeb_loader_chk.sv
module eeb_loader_chk #(
  parameter int EE_AW  = 10,
  parameter int BASE_W = 9,
  parameter int MEM_AW = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              ee_req,
  input logic              ee_ack,
  input logic              ee_we,
  input logic [EE_AW-1:0]  ee_addr,
  input logic [7:0]        ee_wdata,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [BASE_W-1:0] base_q
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata)));

  assert_mem_after_read_R12: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(ee_req && ee_ack && !ee_we));

  assert_mem_base_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[MEM_AW-1:MEM_AW-BASE_W] == base_q));

  assert_mem_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
endmodule

bind eeb_loader eeb_loader_chk u_chk (
  .clk(clk), .rst(rst), .ee_req(ee_req), .ee_ack(ee_ack), .ee_we(ee_we),
  .ee_addr(ee_addr), .ee_wdata(ee_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
  .base_q(base_q)
);

// File: tb/eeb_loader_test.sv
`timescale 1ns/1ps
module eeb_loader_test;
  localparam int LAT = 3;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_we = 1'b0;
  logic [2:0] host_sel = 3'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic ee_req, ee_we, ee_ack, mem_we;
  logic [9:0] ee_addr;
  logic [7:0] ee_wdata, ee_rdata;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata;

  always #2.5 clk = ~clk;

  eeb_loader uut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ee_req(ee_req),
    .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_rdata(ee_rdata),
    .ee_ack(ee_ack), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  logic [7:0] rom [1024];
  int cnt;
  always @(posedge clk) begin
    if (rst) begin
      ee_ack <= 1'b0; cnt <= 0; ee_rdata <= 8'h00;
    end else if (ee_ack) begin
      ee_ack <= 1'b0; cnt <= 0;
    end else if (ee_req) begin
      if (cnt == LAT - 1) begin
        ee_ack <= 1'b1;
        ee_rdata <= rom[ee_addr];
        if (ee_we) rom[ee_addr] <= ee_wdata;
      end else cnt <= cnt + 1;
    end
  end

  logic [23:0] cap_a [16];
  logic [31:0] cap_d [16];
  int ncap = 0;
  always @(posedge clk) if (!rst && mem_we && ncap < 16) begin
    cap_a[ncap] <= mem_addr; cap_d[ncap] <= mem_wdata; ncap <= ncap + 1;
  end

  int hs_err = 0;
  logic prev_wait = 1'b0;
  logic [9:0] prev_addr = '0;
  always @(posedge clk) if (!rst) begin
    if (prev_wait && (!ee_req || ee_addr != prev_addr)) hs_err <= hs_err + 1;
    prev_wait <= ee_req && !ee_ack;
    prev_addr <= ee_addr;
  end

  int checks = 0, fails = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk); host_we = 1'b1; host_sel = sel; host_wdata = val;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] sel, output logic [31:0] v);
    @(negedge clk); host_sel = sel;
    @(negedge clk); v = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c, b;
    for (int n = 0; n < 400; n++) begin
      rreg(3'd0, c); rreg(3'd4, b);
      if (c == 0 && b == 0) return;
    end
    chk("R5 busy never cleared", 32'd1, 32'd0);
  endtask

  localparam logic [18:0] VEC [8] = '{
    {1'b0, 10'h020, 8'h5A}, {1'b0, 10'h021, 8'hC3}, {1'b0, 10'h03A, 8'h00},
    {1'b1, 10'h021, 8'hC3}, {1'b1, 10'h020, 8'h5A}, {1'b1, 10'h03A, 8'h00},
    {1'b0, 10'h040, 8'h7E}, {1'b1, 10'h040, 8'h7E}};

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) rom[i] = 8'h00;
    rom[0] = 8'h12; rom[1] = 8'h80; rom[2] = 8'h11; rom[3] = 8'h22; rom[4] = 8'h33; rom[5] = 8'h44;
    rom[6] = 8'h00; rom[7] = 8'h01; rom[8] = 8'hAA; rom[9] = 8'hBB; rom[10] = 8'hCC; rom[11] = 8'hDD;
    rom[12] = 8'hFF; rom[13] = 8'hFF;
    rom[10'h03A] = 8'h66;
    rom[10'h041] = 8'h03; rom[10'h042] = 8'h00; rom[10'h043] = 8'h01; rom[10'h044] = 8'h02;
    rom[10'h045] = 8'h03; rom[10'h046] = 8'h04; rom[10'h047] = 8'hFF; rom[10'h048] = 8'hFF;
    rom[10'h3F8] = 8'h99; rom[10'h3F9] = 8'h07; rom[10'h3FA] = 8'h00; rom[10'h3FB] = 8'h5A;
    rom[10'h3FC] = 8'h6B; rom[10'h3FD] = 8'h7C; rom[10'h3FE] = 8'h8D;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int s = 0; s < 5; s++) begin
      rreg(3'(s), v); chk("R1 register reset value", v, 32'd0);
    end
    chk("R1 ee_req low", 32'(ee_req), 32'd0);
    chk("R1 mem_we low", 32'(mem_we), 32'd0);

    // R6 R8 R9 R5: fresh burst from address 0
    wreg(3'd3, 32'h1A5);
    wreg(3'd4, 32'h1);
    rreg(3'd4, v); chk("R5 burst bit set while running", v, 32'd1);
    wait_idle();
    chk("R9 terminator adds no write", 32'(ncap), 32'd2);
    chk("R6 R8 first record address, bit15 dropped", 32'(cap_a[0]), 32'h00D28012);
    chk("R8 first record word", cap_d[0], 32'h44332211);
    chk("R8 second record address", 32'(cap_a[1]), 32'h00D28100);
    chk("R8 second record word", cap_d[1], 32'hDDCCBBAA);

    // R2 R3: single accesses from the vector table
    for (int i = 0; i < 8; i++) begin
      wreg(3'd1, 32'(VEC[i][17:8]));
      if (VEC[i][18]) begin
        wreg(3'd0, 32'h2); wait_idle();
        rreg(3'd2, v); chk("R3 read byte", v, 32'(VEC[i][7:0]));
      end else begin
        wreg(3'd2, 32'(VEC[i][7:0]));
        wreg(3'd0, 32'h1); wait_idle();
        rreg(3'd0, v); chk("R2 control cleared", v, 32'd0);
        chk("R2 byte stored", 32'(rom[VEC[i][17:8]]), 32'(VEC[i][7:0]));
      end
    end
    chk("R12 single accesses write no memory", 32'(ncap), 32'd2);

    // R7: burst resumes after last single access (0x40)
    wreg(3'd4, 32'h1); wait_idle();
    chk("R7 continuation count", 32'(ncap), 32'd3);
    chk("R7 continuation address", 32'(cap_a[2]), 32'h00D28003);
    chk("R7 continuation word", cap_d[2], 32'h04030201);

    // R10: burst hits top address
    wreg(3'd3, 32'h3);
    wreg(3'd1, 32'h3F8); wreg(3'd0, 32'h2); wait_idle();
    rreg(3'd2, v); chk("R3 read near top", v, 32'h99);
    wreg(3'd4, 32'h1); wait_idle();
    chk("R10 one word before top", 32'(ncap), 32'd4);
    chk("R10 record address", 32'(cap_a[3]), 32'h00018007);
    chk("R10 record word", cap_d[3], 32'h8D7C6B5A);

    // R7: next burst wrapped to address 0
    wreg(3'd4, 32'h1); wait_idle();
    chk("R7 wrapped burst count", 32'(ncap), 32'd6);
    chk("R7 wrapped burst address", 32'(cap_a[4]), 32'h00018012);

    // R11: writes while busy are ignored
    wreg(3'd1, 32'h020);
    @(negedge clk); host_we = 1'b1; host_sel = 3'd0; host_wdata = 32'h2;
    @(negedge clk); host_sel = 3'd0; host_wdata = 32'h1;
    @(negedge clk); host_sel = 3'd1; host_wdata = 32'h033;
    @(negedge clk); host_sel = 3'd4; host_wdata = 32'h1;
    @(negedge clk); host_sel = 3'd2; host_wdata = 32'hEE;
    @(negedge clk); host_we = 1'b0;
    wait_idle();
    rreg(3'd2, v); chk("R11 data holds read result", v, 32'h5A);
    rreg(3'd1, v); chk("R11 address unchanged", v, 32'h020);
    chk("R11 store byte unchanged", 32'(rom[10'h020]), 32'h5A);
    chk("R11 no burst started", 32'(ncap), 32'd6);

    // R3: both request bits -> read only
    wreg(3'd1, 32'h021); wreg(3'd0, 32'h3); wait_idle();
    rreg(3'd2, v); chk("R3 both bits read", v, 32'hC3);
    chk("R3 both bits no write", 32'(rom[10'h021]), 32'hC3);

    chk("R4 handshake held until ack", 32'(hs_err), 32'd0);
    summary();
  end
endmodule